// File: doc/BRIEF.md
# Inverted Page Table Walker

This block turns a virtual address issued on behalf of a process into a physical address. The translation table holds one entry per physical frame, so entry position i describes frame i. Each entry records whether it is in use, which process owns it, which virtual page it maps, and a link to the next entry that shares its hash bucket. A small, separate anchor table gives the first entry of each bucket. Both tables live in synchronous single-port-read RAMs inside the block.

A request carries a process identifier and a virtual address. The address is split into a page number and an in-page offset. The walker hashes the page number with the process identifier to pick an anchor slot, reads the first chain index from it, and then visits one chain entry per clock. It stops on the first entry whose owner and page tag both match, and answers with the frame number joined to the unchanged offset. If the bucket is empty, the chain ends, or the walk runs longer than the number of frames, it answers with a page fault instead.

An external agent fills the tables through a write port while the walker is idle. It can install an entry, invalidate it, or relink the anchors and the chain pointers.

Top module: `ipt_walker`

## Requirements
- R1: After a synchronous reset, `req_ready` is 1 and `rsp_valid` is 0.
- R2: The anchor slot for a request is `(page[IDX_W-1:0] XOR pid)` truncated to IDX_W bits. Only the chain reached through that slot is searched.
- R3: A hit sets `rsp_hit`=1 and `rsp_fault`=0. The physical address is `{frame index, offset}`, and the offset is the low OFF_W bits of the request address.
- R4: The walker follows the chain through each entry's next field, one entry per clock. A hit on the m-th entry of the chain gives `rsp_valid` m+1 cycles after the accepting edge.
- R5: An anchor value of all ones (IDX_W+1 bits) means the bucket is empty. That case faults 1 cycle after acceptance. A next value of all ones ends the chain. A chain of L entries with no match faults L+1 cycles after acceptance.
- R6: An entry matches only if both its process identifier and its page tag equal the request's. The same page tag under another process is passed over.
- R7: An entry with its valid bit at 0 never matches, but its next field is still followed.
- R8: A walk that has visited 2**IDX_W entries without a hit stops with a fault, 2**IDX_W+1 cycles after acceptance. This also ends a walk around a cyclic chain.
- R9: `req_ready` is 0 while a walk is in progress and in any cycle where `wr_en` is 1. A request is accepted only on an edge where both `req_valid` and `req_ready` are 1. `rsp_valid` is a single-cycle pulse.
- R10: A write presented while a walk is in progress is ignored. It changes neither table. When idle, `wr_sel`=0 writes the entry at `wr_idx` and `wr_sel`=1 writes the anchor at `wr_idx` with `wr_nxt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_pid | input | PID_W | Process identifier of the request |
| req_vaddr | input | VPN_W+OFF_W | Virtual address: page number above the offset |
| rsp_valid | output | 1 | Single-cycle response strobe |
| rsp_hit | output | 1 | Translation found |
| rsp_fault | output | 1 | Page not resident |
| rsp_paddr | output | IDX_W+OFF_W | Frame number joined to the offset (zero on fault) |
| wr_en | input | 1 | Table write strobe, taken only when idle |
| wr_sel | input | 1 | 0 writes an entry, 1 writes an anchor |
| wr_idx | input | IDX_W | Entry or anchor position to write |
| wr_vld | input | 1 | Valid bit for an entry write |
| wr_pid | input | PID_W | Owner for an entry write |
| wr_vpn | input | VPN_W | Page tag for an entry write |
| wr_nxt | input | IDX_W+1 | Next link (entry write) or first index (anchor write) |

## Verification
Lookups are run against a three-entry chain. Hits on the first, second and third links separate correct pointer following from a walk that stops early, and the response cycle shows how far the walk went. Several requests are tested in one bucket:
- a page absent from that bucket, to check that the chain end is honoured;
- a page whose hash reaches an empty slot, to check the empty-bucket path;
- a page whose hash lands in the populated bucket without a match, to check that the hash picks the bucket.

An entry is placed with the right page tag but the wrong owner, and another is invalidated. Both must be passed over while their links are still followed. A two-entry loop must end in the bounded fault. Writes issued during that walk are then checked by a later lookup to confirm they were ignored.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ANCH = 2'd1,
    ST_WALK = 2'd2
  } walk_state_e;

endpackage

// File: rtl/ipt_hash.sv
module ipt_hash #(
  parameter int PID_W = 4,
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0] page_lo,
  input  logic [PID_W-1:0] pid,
  output logic [IDX_W-1:0] slot
);

  logic [IDX_W-1:0] pid_fit;

  generate
    if (PID_W >= IDX_W) begin : g_trunc
      assign pid_fit = pid[IDX_W-1:0];
    end else begin : g_ext
      assign pid_fit = {{(IDX_W-PID_W){1'b0}}, pid};
    end
  endgenerate

  assign slot = page_lo ^ pid_fit;

endmodule

// File: rtl/ipt_ram.sv
module ipt_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    if (re) begin
      rdata <= mem[raddr];
    end
  end

endmodule

// File: rtl/ipt_walker.sv
module ipt_walker
  import ipt_pkg::*;
#(
  parameter int VPN_W = 12,
  parameter int OFF_W = 8,
  parameter int PID_W = 4,
  parameter int IDX_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [PID_W-1:0]         req_pid,
  input  logic [VPN_W+OFF_W-1:0]   req_vaddr,
  output logic                     rsp_valid,
  output logic                     rsp_hit,
  output logic                     rsp_fault,
  output logic [IDX_W+OFF_W-1:0]   rsp_paddr,
  input  logic                     wr_en,
  input  logic                     wr_sel,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic                     wr_vld,
  input  logic [PID_W-1:0]         wr_pid,
  input  logic [VPN_W-1:0]         wr_vpn,
  input  logic [IDX_W:0]           wr_nxt
);

  localparam int NFR   = 1 << IDX_W;
  localparam int NXT_W = IDX_W + 1;
  localparam int VA_W  = VPN_W + OFF_W;
  localparam int ENT_W = 1 + PID_W + VPN_W + NXT_W;
  localparam int CNT_W = $clog2(NFR + 1);
  localparam logic [NXT_W-1:0] END_PTR  = '1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(NFR - 1);

  typedef struct packed {
    logic             vld;
    logic [PID_W-1:0] pid;
    logic [VPN_W-1:0] vpn;
    logic [NXT_W-1:0] nxt;
  } ent_t;

  walk_state_e      state;
  logic [PID_W-1:0] pid_q;
  logic [VPN_W-1:0] vpn_q;
  logic [OFF_W-1:0] off_q;
  logic [IDX_W-1:0] cur_idx;
  logic [CNT_W-1:0] visit_cnt;

  logic             idle;
  logic             accept;
  logic             wr_ok;
  logic [IDX_W-1:0] slot;
  logic [NXT_W-1:0] anc_q;
  logic [ENT_W-1:0] tbl_raw;
  ent_t             ent;
  ent_t             wr_ent;
  logic             tbl_re;
  logic [IDX_W-1:0] tbl_ra;
  logic             tag_hit;
  logic             chain_end;
  logic             at_limit;
  logic             anc_empty;

  assign idle      = (state == ST_IDLE);
  assign req_ready = idle && !wr_en;
  assign accept    = req_valid && req_ready;
  assign wr_ok     = wr_en && idle;

  ipt_hash #(
    .PID_W (PID_W),
    .IDX_W (IDX_W)
  ) hash_i (
    .page_lo (req_vaddr[OFF_W +: IDX_W]),
    .pid     (req_pid),
    .slot    (slot)
  );

  ipt_ram #(
    .DATA_W (NXT_W),
    .ADDR_W (IDX_W)
  ) anchor_ram_i (
    .clk   (clk),
    .we    (wr_ok && wr_sel),
    .waddr (wr_idx),
    .wdata (wr_nxt),
    .re    (accept),
    .raddr (slot),
    .rdata (anc_q)
  );

  always_comb begin
    wr_ent.vld = wr_vld;
    wr_ent.pid = wr_pid;
    wr_ent.vpn = wr_vpn;
    wr_ent.nxt = wr_nxt;
  end

  ipt_ram #(
    .DATA_W (ENT_W),
    .ADDR_W (IDX_W)
  ) frame_ram_i (
    .clk   (clk),
    .we    (wr_ok && !wr_sel),
    .waddr (wr_idx),
    .wdata (wr_ent),
    .re    (tbl_re),
    .raddr (tbl_ra),
    .rdata (tbl_raw)
  );

  assign ent       = ent_t'(tbl_raw);
  assign tag_hit   = ent.vld && (ent.pid == pid_q) && (ent.vpn == vpn_q);
  assign chain_end = (ent.nxt == END_PTR);
  assign at_limit  = (visit_cnt == LAST_CNT);
  assign anc_empty = (anc_q == END_PTR);

  // next table read: first link from the anchor, later links from the entry
  always_comb begin
    tbl_re = 1'b0;
    tbl_ra = ent.nxt[IDX_W-1:0];
    case (state)
      ST_ANCH: begin
        tbl_re = !anc_empty;
        tbl_ra = anc_q[IDX_W-1:0];
      end
      ST_WALK: begin
        tbl_re = !tag_hit && !chain_end && !at_limit;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      pid_q     <= '0;
      vpn_q     <= '0;
      off_q     <= '0;
      cur_idx   <= '0;
      visit_cnt <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            pid_q <= req_pid;
            vpn_q <= req_vaddr[VA_W-1:OFF_W];
            off_q <= req_vaddr[OFF_W-1:0];
            state <= ST_ANCH;
          end
        end
        ST_ANCH: begin
          if (anc_empty) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b0;
            rsp_fault <= 1'b1;
            rsp_paddr <= '0;
            state     <= ST_IDLE;
          end else begin
            cur_idx   <= anc_q[IDX_W-1:0];
            visit_cnt <= '0;
            state     <= ST_WALK;
          end
        end
        ST_WALK: begin
          if (tag_hit) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b1;
            rsp_fault <= 1'b0;
            rsp_paddr <= {cur_idx, off_q};
            state     <= ST_IDLE;
          end else if (chain_end || at_limit) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b0;
            rsp_fault <= 1'b1;
            rsp_paddr <= '0;
            state     <= ST_IDLE;
          end else begin
            cur_idx   <= ent.nxt[IDX_W-1:0];
            visit_cnt <= visit_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: a response is exactly one of hit or fault
  p_hit_xor_fault_r3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_hit ^ rsp_fault));

  // R3: a hit keeps the request offset
  p_offset_kept_r3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> (rsp_paddr[OFF_W-1:0] == off_q));

  // R9: an accepted request makes the walker busy
  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (rst)
    accept |=> !req_ready);

  // R9: response is a single-cycle pulse
  p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R8: the walk never visits more entries than there are frames
  p_visit_bound_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WALK) |-> (visit_cnt < CNT_W'(NFR)));

endmodule

// File: tb/ipt_walker_tb_top.sv
`timescale 1ns/1ps
module ipt_walker_tb_top;

  localparam int VPN_W = 12;
  localparam int OFF_W = 8;
  localparam int PID_W = 4;
  localparam int IDX_W = 4;
  localparam int NFR   = 16;
  localparam logic [4:0] ENDP = 5'h1F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_pid = '0;
  logic [19:0] req_vaddr = '0;
  logic        rsp_valid, rsp_hit, rsp_fault;
  logic [11:0] rsp_paddr;
  logic        wr_en = 1'b0, wr_sel = 1'b0, wr_vld = 1'b0;
  logic [3:0]  wr_idx = '0, wr_pid = '0;
  logic [11:0] wr_vpn = '0;
  logic [4:0]  wr_nxt = '0;

  always #2 clk = ~clk;

  ipt_walker #(.VPN_W(VPN_W), .OFF_W(OFF_W), .PID_W(PID_W), .IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_pid(req_pid), .req_vaddr(req_vaddr), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx), .wr_vld(wr_vld),
    .wr_pid(wr_pid), .wr_vpn(wr_vpn), .wr_nxt(wr_nxt));

  typedef struct {
    logic       hit;
    logic [3:0] frame;
    logic [7:0] off;
    int         ecyc;
    string      tag;
  } exp_t;

  exp_t  q[$];
  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  bit    done = 0;
  bit    prev_v = 0;

  logic        m_vld [NFR];
  logic [3:0]  m_pid [NFR];
  logic [11:0] m_vpn [NFR];
  logic [4:0]  m_nxt [NFR];
  logic [4:0]  m_anc [NFR];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_v) chk(!rsp_valid, "R9 pulse", rsp_valid, 0);
      prev_v <= rsp_valid;
      if (rsp_valid) begin
        if (q.size() == 0) begin
          chk(1'b0, "R9 unexpected response", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(rsp_hit == e.hit && rsp_fault == !e.hit, {e.tag, " hit"}, rsp_hit, e.hit);
          if (e.hit) chk(rsp_paddr == {e.frame, e.off}, {e.tag, " paddr"}, rsp_paddr, {e.frame, e.off});
          chk(cyc == e.ecyc, {e.tag, " latency"}, cyc, e.ecyc);
        end
      end
    end
  end

  function automatic void model(input logic [3:0] pid, input logic [11:0] vpn,
                                output logic hit, output logic [3:0] fr, output int lat);
    logic [3:0] h;
    logic [3:0] idx;
    hit = 1'b0; fr = '0; lat = 1;
    h = vpn[3:0] ^ pid;
    if (m_anc[h] == ENDP) return;
    idx = m_anc[h][3:0];
    for (int v = 1; v <= NFR; v++) begin
      if (m_vld[idx] && m_pid[idx] == pid && m_vpn[idx] == vpn) begin
        hit = 1'b1; fr = idx; lat = 1 + v; return;
      end
      if (m_nxt[idx] == ENDP || v == NFR) begin
        lat = 1 + v; return;
      end
      idx = m_nxt[idx][3:0];
    end
  endfunction

  task automatic wait_idle();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr_ent(input logic [3:0] idx, input logic v, input logic [3:0] pid,
                        input logic [11:0] vpn, input logic [4:0] nxt);
    wait_idle();
    wr_en = 1; wr_sel = 0; wr_idx = idx; wr_vld = v; wr_pid = pid; wr_vpn = vpn; wr_nxt = nxt;
    m_vld[idx] = v; m_pid[idx] = pid; m_vpn[idx] = vpn; m_nxt[idx] = nxt;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wr_anc(input logic [3:0] idx, input logic [4:0] nxt);
    wait_idle();
    wr_en = 1; wr_sel = 1; wr_idx = idx; wr_nxt = nxt;
    m_anc[idx] = nxt;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic lookup(input logic [3:0] pid, input logic [11:0] vpn,
                        input logic [7:0] off, input string tag);
    exp_t e;
    logic h; logic [3:0] f; int lat;
    model(pid, vpn, h, f, lat);
    @(negedge clk);
    req_valid = 1; req_pid = pid; req_vaddr = {vpn, off};
    while (!req_ready) @(negedge clk);
    e.hit = h; e.frame = f; e.off = off; e.ecyc = cyc + 1 + lat; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);

    // R9: write strobe blocks acceptance
    wr_en = 1; wr_sel = 1; wr_idx = 0; wr_nxt = ENDP; m_anc[0] = ENDP;
    #1 chk(req_ready == 1'b0, "R9 ready low during write", req_ready, 0);
    @(negedge clk); wr_en = 0;

    for (int i = 0; i < NFR; i++) begin
      wr_anc(4'(i), ENDP);
      wr_ent(4'(i), 1'b0, 4'h0, 12'h000, ENDP);
    end

    // bucket 3 chain: 5 -> 9 -> 12
    wr_ent(4'd5, 1, 4'h2, 12'h031, 5'd9);
    wr_ent(4'd9, 1, 4'h3, 12'h040, 5'd12);
    wr_ent(4'd12, 1, 4'h1, 12'h122, ENDP);
    wr_anc(4'd3, 5'd5);

    lookup(4'h2, 12'h031, 8'h3C, "R3 first link hit");
    lookup(4'h3, 12'h040, 8'h01, "R4 second link hit");
    lookup(4'h1, 12'h122, 8'hFE, "R4 third link hit");
    lookup(4'h2, 12'h777, 8'h00, "R5 empty bucket fault");
    lookup(4'h0, 12'h003, 8'h00, "R5 chain end fault");
    lookup(4'h4, 12'h037, 8'h00, "R2 hashed into bucket 3");

    // bucket 0: 4{pid8,050} -> 2{pid0,050}
    wr_ent(4'd2, 1, 4'h0, 12'h050, ENDP);
    wr_ent(4'd4, 1, 4'h8, 12'h050, 5'd2);
    wr_anc(4'd0, 5'd4);
    lookup(4'h0, 12'h050, 8'h77, "R6 pid mismatch skipped");

    // R7: invalidate head of bucket 3, link kept
    wr_ent(4'd5, 0, 4'h2, 12'h031, 5'd9);
    lookup(4'h2, 12'h031, 8'h3C, "R7 invalid entry no match");
    lookup(4'h3, 12'h040, 8'h02, "R7 link through invalid");

    // R8: cyclic chain in bucket 1
    wr_ent(4'd10, 1, 4'hF, 12'hFFF, 5'd11);
    wr_ent(4'd11, 1, 4'hF, 12'hFFE, 5'd10);
    wr_anc(4'd1, 5'd10);
    wait_idle();
    lookup(4'h0, 12'h001, 8'h11, "R8 cyclic abort");
    chk(req_ready == 1'b0, "R9 ready low while walking", req_ready, 0);
    // R10: writes during the walk must be dropped (model not updated)
    wr_en = 1; wr_sel = 1; wr_idx = 4'd5; wr_nxt = 5'd6;
    @(negedge clk);
    wr_sel = 0; wr_idx = 4'd6; wr_vld = 1; wr_pid = 4'h2; wr_vpn = 12'h777; wr_nxt = ENDP;
    @(negedge clk);
    wr_en = 0;
    lookup(4'h2, 12'h777, 8'h00, "R10 busy write ignored");

    wr_ent(4'd6, 1, 4'h2, 12'h777, ENDP);
    wr_anc(4'd5, 5'd6);
    lookup(4'h2, 12'h777, 8'h5A, "R10 idle write taken");

    wait_idle();
    repeat (5) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule